// File: doc/BRIEF.md
# Phased Bus Write Register Interface

This block sits on the peripheral side of a shared parallel bus whose period is split into a controller phase and a peripheral phase. In the controller phase the controller drives an address, a read/write flag and the write data together. The block compares the address with a small window of register addresses. It forms one active-low write strobe for each register and stores the bus data into the chosen register.

The write strobe for a register goes low only when three things are true at once: the address points at that register, the transfer is a write, and the bus is in the peripheral phase. The capture itself is a synchronous enable on an ordinary system-clock flop. It takes place at the rising edge that ends the peripheral-phase cycle, which is also the edge where the strobe rises back to its resting high level. No clock is gated. The address window starts at a base address set by a parameter. The block also gives a decoded indication, which is high whenever the window is addressed during the peripheral phase.

Top module: `phased_wr_regs`

## Requirements
- R1: While rst_ni is low, every register output is 0 and every bit of strobe_n_o is 1. After reset is released, the registers read 0 until they are written.
- R2: strobe_n_o[k] is 0 exactly when rst_ni=1, phase_i=1 (peripheral phase), rw_i=0 (write) and addr_i equals BASE+k. Otherwise it is 1.
- R3: At most one bit of strobe_n_o is 0 at any time.
- R4: If strobe_n_o[k] is 0 during a cycle, register k holds that cycle's data_i after the next rising edge of clk_i. Register k occupies bits [8k+7:8k] of regs_o.
- R5: During the controller phase (phase_i=0), a write with a matching address leaves every register unchanged.
- R6: A read (rw_i=1) leaves every register unchanged, even during the peripheral phase and with a matching address.
- R7: An address outside BASE..BASE+3 drives no strobe low and changes no register.
- R8: decoded_o is 1 exactly when phase_i=1 and addr_i lies within BASE..BASE+3. This holds for both reads and writes.
- R9: Writes in consecutive peripheral-phase cycles each land, one per clock, in their own target registers.
- R10: A write to register k leaves every other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; a rising edge ends each phase cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| phase_i | input | 1 | 1 = peripheral phase, 0 = controller phase |
| rw_i | input | 1 | Transfer type: 1 = read, 0 = write |
| addr_i | input | 8 | Bus address |
| data_i | input | 8 | Bus write data |
| decoded_o | output | 1 | Window addressed during the peripheral phase |
| strobe_n_o | output | 4 | Active-low per-register write strobes |
| regs_o | output | 32 | Contents of the four registers, register 0 in the low byte |

## Verification
The strobes and decoded_o are combinational, so they are due in the same cycle as the bus inputs. The bench checks them shortly after it drives the inputs on the falling edge. A register update is due one rising edge after a cycle with a low strobe. The bench's reference model applies the write at that rising edge, and the register outputs are compared on the following falling edge, once in every cycle. Because the comparison runs every cycle, an early capture, a late capture or a stray capture (controller phase, read, out of window) shows up as a mismatch within that same cycle.

// File: rtl/phw_pkg.sv
package phw_pkg;
  typedef enum logic {
    XFER_WRITE = 1'b0,
    XFER_READ  = 1'b1
  } xfer_e;

  typedef enum logic {
    PH_CTRL   = 1'b0,
    PH_PERIPH = 1'b1
  } phase_e;
endpackage

// File: rtl/phw_addr_decode.sv
module phw_addr_decode #(
  parameter int unsigned AW = 8,
  parameter int unsigned NREG = 4,
  parameter logic [AW-1:0] BASE = 8'h40
) (
  input  logic [AW-1:0]   addr_i,
  output logic            in_win_o,
  output logic [NREG-1:0] sel_oh_o
);
  localparam int unsigned OW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [AW:0] BASE_W = {1'b0, BASE};
  localparam logic [AW:0] NREG_W = (AW+1)'(NREG);

  logic [AW:0] diff;

  // borrow in the top bit marks addresses below the window
  assign diff     = {1'b0, addr_i} - BASE_W;
  assign in_win_o = !diff[AW] && (diff < NREG_W);

  for (genvar k = 0; k < NREG; k++) begin : g_sel
    assign sel_oh_o[k] = in_win_o && (diff[OW-1:0] == OW'(k));
  end
endmodule

// File: rtl/phw_strobe_gen.sv
module phw_strobe_gen #(
  parameter int unsigned NREG = 4
) (
  input  logic            rst_ni,
  input  logic            phase_i,
  input  logic            rw_i,
  input  logic [NREG-1:0] sel_oh_i,
  output logic [NREG-1:0] strobe_n_o
);
  import phw_pkg::*;

  logic wr_qual;

  // write qualified by the peripheral phase; inverted so the strobe rises at phase end
  assign wr_qual = rst_ni && (phase_e'(phase_i) == PH_PERIPH) && (xfer_e'(rw_i) == XFER_WRITE);

  for (genvar k = 0; k < NREG; k++) begin : g_stb
    assign strobe_n_o[k] = ~(wr_qual & sel_oh_i[k]);
  end
endmodule

// File: rtl/phw_reg_bank.sv
module phw_reg_bank #(
  parameter int unsigned DW = 8,
  parameter int unsigned NREG = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NREG-1:0]  strobe_n_i,
  input  logic [DW-1:0]    data_i,
  output logic [NREG*DW-1:0] regs_o
);
  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            q <= '0;
      else if (!strobe_n_i[k]) q <= data_i;
    end
    assign regs_o[k*DW +: DW] = q;
  end
endmodule

// File: rtl/phased_wr_regs.sv
module phased_wr_regs #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  parameter int unsigned NREG = 4,
  parameter logic [AW-1:0] BASE = 8'h40
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               phase_i,
  input  logic               rw_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      data_i,
  output logic               decoded_o,
  output logic [NREG-1:0]    strobe_n_o,
  output logic [NREG*DW-1:0] regs_o
);
  logic            in_win;
  logic [NREG-1:0] sel_oh;

  phw_addr_decode #(.AW(AW), .NREG(NREG), .BASE(BASE)) u_dec (
    .addr_i   (addr_i),
    .in_win_o (in_win),
    .sel_oh_o (sel_oh)
  );

  phw_strobe_gen #(.NREG(NREG)) u_stb (
    .rst_ni     (rst_ni),
    .phase_i    (phase_i),
    .rw_i       (rw_i),
    .sel_oh_i   (sel_oh),
    .strobe_n_o (strobe_n_o)
  );

  phw_reg_bank #(.DW(DW), .NREG(NREG)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strobe_n_i (strobe_n_o),
    .data_i     (data_i),
    .regs_o     (regs_o)
  );

  assign decoded_o = phase_i && in_win;
endmodule

// File: rtl/phw_checker.sv
module phw_checker #(
  parameter int unsigned DW = 8,
  parameter int unsigned NREG = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               phase_i,
  input logic               rw_i,
  input logic [DW-1:0]      data_i,
  input logic               decoded_o,
  input logic [NREG-1:0]    strobe_n_o,
  input logic [NREG*DW-1:0] regs_o
);
  p_rst_idle_r1: assert property (@(posedge clk_i) !rst_ni |-> (&strobe_n_o && regs_o == '0));

  p_one_strobe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(~strobe_n_o));

  p_ctrl_phase_r5: assert property (@(posedge clk_i) disable iff (!rst_ni) !phase_i |-> &strobe_n_o);

  p_read_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni) rw_i |-> &strobe_n_o);

  p_stb_decoded_r8: assert property (@(posedge clk_i) disable iff (!rst_ni) !(&strobe_n_o) |-> decoded_o);

  for (genvar k = 0; k < NREG; k++) begin : g_chk
    p_capture_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !strobe_n_o[k] |=> regs_o[k*DW +: DW] == $past(data_i));
    p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      strobe_n_o[k] |=> $stable(regs_o[k*DW +: DW]));
  end
endmodule

bind phased_wr_regs phw_checker #(.DW(DW), .NREG(NREG)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .phase_i    (phase_i),
  .rw_i       (rw_i),
  .data_i     (data_i),
  .decoded_o  (decoded_o),
  .strobe_n_o (strobe_n_o),
  .regs_o     (regs_o)
);

// File: tb/phased_wr_regs_test.sv
module phased_wr_regs_test;
  localparam int PERIOD = 10;
  localparam int BASE = 'h40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phase = 1'b0;
  logic        rw = 1'b1;
  logic [7:0]  addr = '0;
  logic [7:0]  data = '0;
  logic        decoded;
  logic [3:0]  strobe_n;
  logic [31:0] regs;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int model [4] = '{0, 0, 0, 0};

  always #(PERIOD/2) clk = ~clk;

  phased_wr_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .phase_i(phase), .rw_i(rw),
    .addr_i(addr), .data_i(data), .decoded_o(decoded),
    .strobe_n_o(strobe_n), .regs_o(regs)
  );

  function automatic bit in_win(input logic [7:0] a);
    return (int'(a) >= BASE) && (int'(a) < BASE + 4);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_regs(input string tag);
    for (int k = 0; k < 4; k++) check(tag, int'(regs[k*8 +: 8]), model[k]);
  endtask

  // entered at a falling edge; drive, check comb outputs, step model at rising edge, check regs
  task automatic cyc(input bit ph, input bit r, input logic [7:0] a, input logic [7:0] d, input string tag);
    int exp_stb;
    bit wr;
    phase = ph; rw = r; addr = a; data = d;
    #1;
    wr = rst_n && ph && !r && in_win(a);
    exp_stb = 'hF;
    if (wr) exp_stb[int'(a) - BASE] = 1'b0;
    check("R2 strobe", int'(strobe_n), exp_stb);
    check("R3 onehot", int'($countones(~strobe_n) <= 1), 1);
    check("R8 decoded", int'(decoded), int'(ph && in_win(a)));
    @(posedge clk);
    if (wr) model[int'(a) - BASE] = int'(d);
    @(negedge clk);
    check_regs(tag);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    phase = 1'b1; rw = 1'b0; addr = 8'h40; data = 8'hAA;
    repeat (3) @(negedge clk);
    check("R1 strobe idle in reset", int'(strobe_n), 'hF);
    check_regs("R1 reset clear");
    rst_n = 1'b1;
    phase = 1'b0; rw = 1'b1;
    @(negedge clk);
    check_regs("R1 after release");

    // R4 R10: each address, alternating controller/peripheral phases
    for (int k = 0; k < 4; k++) begin
      cyc(1'b0, 1'b0, 8'(BASE + k), 8'(8'h11 * (k + 1)), "R5 ctrl phase write");
      cyc(1'b1, 1'b0, 8'(BASE + k), 8'(8'h11 * (k + 1)), "R4 R10 write");
    end
    // R5: matching write only in controller phase
    cyc(1'b0, 1'b0, 8'(BASE + 2), 8'hEE, "R5 ctrl phase no change");
    // R6: reads in peripheral phase at every address
    for (int k = 0; k < 4; k++) cyc(1'b1, 1'b1, 8'(BASE + k), 8'h5A, "R6 read no change");
    // R7: just outside window, both sides, and far away
    cyc(1'b1, 1'b0, 8'(BASE - 1), 8'h77, "R7 below window");
    cyc(1'b1, 1'b0, 8'(BASE + 4), 8'h77, "R7 above window");
    cyc(1'b1, 1'b0, 8'h00, 8'h77, "R7 addr zero");
    cyc(1'b1, 1'b1, 8'hFF, 8'h77, "R7 R8 read out of window");
    // R9: consecutive peripheral writes, including same register twice
    cyc(1'b1, 1'b0, 8'(BASE + 3), 8'hC3, "R9 back-to-back");
    cyc(1'b1, 1'b0, 8'(BASE + 0), 8'hC0, "R9 back-to-back");
    cyc(1'b1, 1'b0, 8'(BASE + 0), 8'h0C, "R9 back-to-back same reg");
    cyc(1'b1, 1'b0, 8'(BASE + 1), 8'hC1, "R9 back-to-back");
    cyc(1'b1, 1'b0, 8'(BASE + 2), 8'hC2, "R9 back-to-back");
    cyc(1'b0, 1'b1, 8'h00, 8'h00, "R6 idle");
    // R1: reset mid-run clears registers
    rst_n = 1'b0;
    #1;
    for (int k = 0; k < 4; k++) model[k] = 0;
    check("R1 strobe idle in reset", int'(strobe_n), 'hF);
    check_regs("R1 async clear");
    @(negedge clk);
    rst_n = 1'b1;
    cyc(1'b1, 1'b0, 8'(BASE + 1), 8'h99, "R4 write after reset");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule